// File: doc/BRIEF.md
# Branch Target Instruction Cache

This block sits between an instruction fetch unit and a slow flash array with a 15-bit byte address space. It keeps up to 32 four-byte instruction lines in a fully associative store. Each stored line carries a 13-bit tag, taken from address bits 14 to 2, and its own valid flag. A fetch that finds a valid line with a matching tag is answered one clock later from the store, and the flash is not touched.

A fetch that misses raises a line request toward the flash and holds it until the flash hands back the whole line. The addressed byte is then returned one clock after the data arrives. While it waits, the block counts how many cycles the fetch stalled. The returned line is kept only when that count is larger than a 2-bit threshold, so short misses can be kept out of the store and room left for branch targets that are expensive to reload.

A mode input picks the slot to overwrite. One setting sweeps the slot index up to the top and back down again, without repeating the end slots. The other setting takes the index from a free-running shift-register sequence. A flush pulse invalidates every line at once.

Top module: `btc_cache`

## Requirements
- R1: A fetch is a hit when some slot is valid and its tag equals fetch address bits 14..2. The cycle after a hit, rsp_valid and rsp_hit are 1 and no flash request is raised. Address bits 1..0 select the byte: 00 returns line bits 7..0 and 11 returns line bits 31..24.
- R2: On a miss, flash_req rises the cycle after the fetch. It carries the line address (bits 1..0 zero) and stays high with a stable address until flash_valid. The cycle after flash_valid, rsp_valid is 1, rsp_hit is 0, rsp_data is the addressed byte of flash_line, and flash_req is 0.
- R3: The stall count is the number of cycles flash_req is high, counting the cycle where flash_valid is seen. It saturates at 7 and does not wrap.
- R4: A returned line is stored only when the stall count is strictly greater than cfg_thresh. With a threshold of 2, stalls of 1 or 2 cycles are not stored and stalls of 3 or 4 are stored. With a threshold of 0, every miss is stored.
- R5: After reset, rsp_valid and flash_req are 0 and every slot is invalid, so the first fetch misses.
- R6: A flush pulse invalidates every slot, and any later fetch of a previously stored line misses.
- R7: When flush is high in the cycle a line returns, the flush takes effect and the returned line is not stored.
- R8: With cfg_random at 0, stored lines go to slots 0,1,…,31, then 30,29,…,0, then 1,2,… and so on. The sweep moves only when a line is stored.
- R9: With cfg_random at 1, the victim slot comes from a linear feedback shift register that steps once per stored line. A line stored in this mode hits on its next fetch.
- R10: A fetch_req raised while a miss is outstanding is ignored: it produces no response and no fill.
- R11: Addresses that differ only in bit 14 belong to different lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_req | input | 1 | Fetch request, accepted when no miss is outstanding |
| fetch_addr | input | 15 | Fetch byte address |
| rsp_valid | output | 1 | Response strobe, one cycle |
| rsp_hit | output | 1 | Response was served from the store |
| rsp_data | output | 8 | Returned instruction byte |
| flash_req | output | 1 | Line request to flash, held until flash_valid |
| flash_addr | output | 15 | Line-aligned flash address |
| flash_valid | input | 1 | Flash line data valid |
| flash_line | input | 32 | Flash line, byte 0 in bits 7..0 |
| cfg_thresh | input | 2 | Miss-penalty threshold |
| cfg_random | input | 1 | Replacement mode: 0 sweep, 1 pseudo-random |
| flush | input | 1 | Invalidate all slots |

## Verification
Flash latency is swept from 1 to 9 cycles against thresholds 0, 2 and 3. This separates a strict greater-than compare from greater-or-equal, and separates a saturating stall counter from a wrapping one, since a 9-cycle stall is kept at threshold 3. Filling all 32 slots and then adding a 33rd line shows whether slot 30 or slot 0 is overwritten, which separates the rebound sweep from a plain wrap. Stray fetches during an outstanding miss, and a flush raised in the exact cycle a line returns, probe the two collision orderings. Byte offsets and bit-14 aliases check the byte select and the tag width.

// File: rtl/btc_pkg.sv
package btc_pkg;
   typedef enum logic {
      MS_IDLE = 1'b0,
      MS_WAIT = 1'b1
   } miss_state_e;
endpackage

// File: rtl/btc_tag_array.sv
module btc_tag_array #(
   parameter int SLOTS  = 32,
   parameter int IDX_W  = 5,
   parameter int TAG_W  = 13,
   parameter int LINE_W = 32
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [TAG_W-1:0]              look_tag,
   output logic [SLOTS-1:0]              hit_vec,
   output logic [LINE_W-1:0]             hit_line,
   input  logic                          flush,
   input  logic                          fill_en,
   input  logic [IDX_W-1:0]              fill_idx,
   input  logic [TAG_W-1:0]              fill_tag,
   input  logic [LINE_W-1:0]             fill_line
);
   logic [SLOTS-1:0][LINE_W-1:0] masked;

   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      logic              vld_q;
      logic [TAG_W-1:0]  tag_q;
      logic [LINE_W-1:0] dat_q;
      logic              sel;

      assign sel = fill_en && (fill_idx == IDX_W'(s));

      // flush has priority over a same-cycle fill
      always_ff @(posedge clk) begin
         if (!rst_n)      vld_q <= 1'b0;
         else if (flush)  vld_q <= 1'b0;
         else if (sel)    vld_q <= 1'b1;
      end

      always_ff @(posedge clk) begin
         if (sel) begin
            tag_q <= fill_tag;
            dat_q <= fill_line;
         end
      end

      assign hit_vec[s] = vld_q && (tag_q == look_tag);
      assign masked[s]  = hit_vec[s] ? dat_q : '0;
   end

   always_comb begin
      hit_line = '0;
      for (int s = 0; s < SLOTS; s++) hit_line = hit_line | masked[s];
   end
endmodule

// File: rtl/btc_victim_sel.sv
module btc_victim_sel #(
   parameter int SLOTS  = 32,
   parameter int IDX_W  = 5,
   parameter int LFSR_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             advance,
   input  logic             use_random,
   output logic [IDX_W-1:0] victim
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(SLOTS - 1);

   logic [IDX_W-1:0]  ptr_q;
   logic              up_q;
   logic [LFSR_W-1:0] lfsr_q;
   logic [LFSR_W-1:0] taps;
   logic              fb;

   if (LFSR_W == 16) begin : g_taps16
      assign taps = LFSR_W'(16'hB400);
   end else if (LFSR_W == 8) begin : g_taps8
      assign taps = LFSR_W'(8'hB8);
   end else begin : g_taps_bad
      $error("btc_victim_sel: LFSR_W must be 8 or 16");
   end

   if (IDX_W > LFSR_W) begin : g_idx_bad
      $error("btc_victim_sel: LFSR narrower than slot index");
   end

   assign fb = ^(lfsr_q & taps);

   // bidirectional sweep pointer, moves only on sweep-mode fills
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q <= '0;
         up_q  <= 1'b1;
      end else if (advance && !use_random) begin
         if (up_q) begin
            if (ptr_q == LAST) begin
               ptr_q <= LAST - IDX_W'(1);
               up_q  <= 1'b0;
            end else begin
               ptr_q <= ptr_q + IDX_W'(1);
            end
         end else begin
            if (ptr_q == '0) begin
               ptr_q <= IDX_W'(1);
               up_q  <= 1'b1;
            end else begin
               ptr_q <= ptr_q - IDX_W'(1);
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                      lfsr_q <= LFSR_W'(1);
      else if (advance && use_random)  lfsr_q <= {lfsr_q[LFSR_W-2:0], fb};
   end

   assign victim = use_random ? lfsr_q[IDX_W-1:0] : ptr_q;
endmodule

// File: rtl/btc_miss_ctrl.sv
module btc_miss_ctrl
   import btc_pkg::*;
#(
   parameter int CNT_W = 3,
   parameter int THR_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             data_rtn,
   input  logic [THR_W-1:0] thresh,
   output logic             busy,
   output logic             alloc
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   miss_state_e      state_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] thr_ext;

   if (CNT_W <= THR_W) begin : g_cnt_bad
      $error("btc_miss_ctrl: counter must be wider than threshold");
   end

   assign thr_ext = {{(CNT_W-THR_W){1'b0}}, thresh};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= MS_IDLE;
         cnt_q   <= '0;
      end else begin
         case (state_q)
            MS_IDLE: if (start) begin
               state_q <= MS_WAIT;
               cnt_q   <= CNT_W'(1);
            end
            MS_WAIT: if (data_rtn) begin
               state_q <= MS_IDLE;
            end else if (cnt_q != CNT_MAX) begin
               cnt_q <= cnt_q + CNT_W'(1);
            end
            default: state_q <= MS_IDLE;
         endcase
      end
   end

   assign busy  = (state_q == MS_WAIT);
   assign alloc = busy && data_rtn && (cnt_q > thr_ext);
endmodule

// File: rtl/btc_cache.sv
module btc_cache #(
   parameter int ADDR_W     = 15,
   parameter int LINE_BYTES = 4,
   parameter int SLOTS      = 32,
   parameter int THR_W      = 2,
   parameter int CNT_W      = 3,
   parameter int LFSR_W     = 16
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      fetch_req,
   input  logic [ADDR_W-1:0]         fetch_addr,
   output logic                      rsp_valid,
   output logic                      rsp_hit,
   output logic [7:0]                rsp_data,
   output logic                      flash_req,
   output logic [ADDR_W-1:0]         flash_addr,
   input  logic                      flash_valid,
   input  logic [LINE_BYTES*8-1:0]   flash_line,
   input  logic [THR_W-1:0]          cfg_thresh,
   input  logic                      cfg_random,
   input  logic                      flush
);
   localparam int OFF_W  = $clog2(LINE_BYTES);
   localparam int TAG_W  = ADDR_W - OFF_W;
   localparam int IDX_W  = $clog2(SLOTS);
   localparam int LINE_W = LINE_BYTES * 8;

   if (LINE_BYTES < 2 || (1 << OFF_W) != LINE_BYTES) begin : g_line_bad
      $error("btc_cache: LINE_BYTES must be a power of two, at least 2");
   end
   if (SLOTS < 2 || (1 << IDX_W) != SLOTS) begin : g_slots_bad
      $error("btc_cache: SLOTS must be a power of two, at least 2");
   end

   logic [SLOTS-1:0]  hit_vec;
   logic [LINE_W-1:0] hit_line;
   logic              any_hit;
   logic              busy;
   logic              accept;
   logic              alloc;
   logic              fill_en;
   logic              line_back;
   logic [IDX_W-1:0]  victim;
   logic [ADDR_W-1:0] pend_q;

   function automatic logic [7:0] pick_byte(input logic [LINE_W-1:0] ln,
                                            input logic [OFF_W-1:0] off);
      return ln[{off, 3'b000} +: 8];
   endfunction

   assign any_hit   = |hit_vec;
   assign accept    = fetch_req && !busy;
   assign line_back = busy && flash_valid;
   assign fill_en   = alloc && !flush;

   btc_tag_array #(
      .SLOTS (SLOTS),
      .IDX_W (IDX_W),
      .TAG_W (TAG_W),
      .LINE_W(LINE_W)
   ) i_tags (
      .clk      (clk),
      .rst_n    (rst_n),
      .look_tag (fetch_addr[ADDR_W-1:OFF_W]),
      .hit_vec  (hit_vec),
      .hit_line (hit_line),
      .flush    (flush),
      .fill_en  (fill_en),
      .fill_idx (victim),
      .fill_tag (pend_q[ADDR_W-1:OFF_W]),
      .fill_line(flash_line)
   );

   btc_miss_ctrl #(
      .CNT_W(CNT_W),
      .THR_W(THR_W)
   ) i_miss (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (accept && !any_hit),
      .data_rtn(flash_valid),
      .thresh  (cfg_thresh),
      .busy    (busy),
      .alloc   (alloc)
   );

   btc_victim_sel #(
      .SLOTS (SLOTS),
      .IDX_W (IDX_W),
      .LFSR_W(LFSR_W)
   ) i_victim (
      .clk       (clk),
      .rst_n     (rst_n),
      .advance   (fill_en),
      .use_random(cfg_random),
      .victim    (victim)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)                    pend_q <= '0;
      else if (accept && !any_hit)   pend_q <= fetch_addr;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_hit   <= 1'b0;
         rsp_data  <= '0;
      end else begin
         rsp_valid <= (accept && any_hit) || line_back;
         rsp_hit   <= accept && any_hit;
         if (accept && any_hit)
            rsp_data <= pick_byte(hit_line, fetch_addr[OFF_W-1:0]);
         else if (line_back)
            rsp_data <= pick_byte(flash_line, pend_q[OFF_W-1:0]);
      end
   end

   assign flash_req  = busy;
   assign flash_addr = {pend_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
endmodule

// File: rtl/btc_cache_chk.sv
module btc_cache_chk #(
   parameter int ADDR_W = 15,
   parameter int SLOTS  = 32,
   parameter int OFF_W  = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              fetch_req,
   input logic              flash_req,
   input logic              flash_valid,
   input logic [ADDR_W-1:0] flash_addr,
   input logic              rsp_valid,
   input logic              rsp_hit,
   input logic              flush,
   input logic [SLOTS-1:0]  hit_vec
);
   p_one_match_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec));

   p_hit_reply_r1: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_req && !flash_req && (|hit_vec) |=> rsp_valid && rsp_hit && !flash_req);

   p_miss_issue_r2: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_req && !flash_req && !(|hit_vec) |=> flash_req && !rsp_valid);

   p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      flash_req && !flash_valid |=> flash_req && $stable(flash_addr));

   p_line_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
      flash_req |-> flash_addr[OFF_W-1:0] == '0);

   p_return_reply_r2: assert property (@(posedge clk) disable iff (!rst_n)
      flash_req && flash_valid |=> rsp_valid && !rsp_hit && !flash_req);

   p_stray_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
      flash_req && !flash_valid && fetch_req |=> !rsp_valid);

   p_flush_empties_r6: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !(|hit_vec)); // also covers R7: a same-cycle fill leaves nothing valid
endmodule

bind btc_cache btc_cache_chk #(
   .ADDR_W(ADDR_W),
   .SLOTS (SLOTS),
   .OFF_W (OFF_W)
) i_btc_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .fetch_req  (fetch_req),
   .flash_req  (flash_req),
   .flash_valid(flash_valid),
   .flash_addr (flash_addr),
   .rsp_valid  (rsp_valid),
   .rsp_hit    (rsp_hit),
   .flush      (flush),
   .hit_vec    (hit_vec)
);

// File: tb/test_btc_cache.sv
module test_btc_cache;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fetch_req = 1'b0;
   logic [14:0] fetch_addr = '0;
   logic        rsp_valid, rsp_hit;
   logic [7:0]  rsp_data;
   logic        flash_req;
   logic [14:0] flash_addr;
   logic        flash_valid = 1'b0;
   logic [31:0] flash_line = '0;
   logic [1:0]  cfg_thresh = 2'd0;
   logic        cfg_random = 1'b0;
   logic        flush;
   logic        flush_a = 1'b0;
   logic        flush_b = 1'b0;

   assign flush = flush_a | flush_b;

   always #4 clk = ~clk;

   btc_cache i_btc_cache (
      .clk        (clk),
      .rst_n      (rst_n),
      .fetch_req  (fetch_req),
      .fetch_addr (fetch_addr),
      .rsp_valid  (rsp_valid),
      .rsp_hit    (rsp_hit),
      .rsp_data   (rsp_data),
      .flash_req  (flash_req),
      .flash_addr (flash_addr),
      .flash_valid(flash_valid),
      .flash_line (flash_line),
      .cfg_thresh (cfg_thresh),
      .cfg_random (cfg_random),
      .flush      (flush)
   );

   typedef struct {
      logic        hit;
      logic [7:0]  data;
      logic [14:0] addr;
      string       req;
   } exp_t;

   exp_t        q[$];
   int          n_chk = 0;
   int          n_fail = 0;
   int          lat_cfg = 1;
   bit          flush_on_fill = 1'b0;
   int          fcnt = 0;
   int          nreq = 0;
   logic [14:0] fl_first = '0;

   function automatic logic [7:0] mem_byte(input logic [14:0] a);
      return 8'(a[7:0] * 8'd7) ^ {1'b0, a[14:8]} ^ 8'h3C;
   endfunction

   function automatic logic [31:0] line_of(input logic [14:0] a);
      logic [31:0] l;
      for (int k = 0; k < 4; k++) l[k*8 +: 8] = mem_byte({a[14:2], 2'(k)});
      return l;
   endfunction

   // flash model: answers lat_cfg cycles after a request starts
   always @(negedge clk) begin
      if (flash_req && !flash_valid) begin
         if (fcnt == 0) begin
            nreq++;
            fl_first = flash_addr;
         end
         fcnt++;
         if (fcnt >= lat_cfg) begin
            flash_valid = 1'b1;
            flash_line  = line_of(flash_addr);
            if (flush_on_fill) flush_b = 1'b1;
         end
      end else begin
         flash_valid = 1'b0;
         flush_b     = 1'b0;
         fcnt        = 0;
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic fetch(input logic [14:0] a, input bit hit, input string req,
                        input int stray = 0, input logic [14:0] sa = '0);
      int   n0;
      exp_t e;
      n0     = nreq;
      e.hit  = hit;
      e.data = mem_byte(a);
      e.addr = a;
      e.req  = req;
      @(negedge clk);
      fetch_addr = a;
      fetch_req  = 1'b1;
      q.push_back(e);
      @(negedge clk);
      if (stray > 0) begin
         fetch_addr = sa;
         repeat (stray) @(negedge clk);
      end
      fetch_req = 1'b0;
      while (q.size() != 0) @(negedge clk);
      check((nreq - n0) == (hit ? 0 : 1), req, "flash request count",
            nreq - n0, hit ? 0 : 1);
      if (!hit)
         check(fl_first == {a[14:2], 2'b00}, "R2", "flash line address",
               int'(fl_first), int'({a[14:2], 2'b00}));
   endtask

   task automatic pulse_flush();
      @(negedge clk); flush_a = 1'b1;
      @(negedge clk); flush_a = 1'b0;
   endtask

   initial begin
      fork
         begin : monitor
            forever begin
               @(negedge clk);
               if (rsp_valid) begin
                  if (q.size() == 0) begin
                     check(1'b0, "R10", "unexpected response", int'(rsp_data), 0);
                  end else begin
                     exp_t e;
                     e = q.pop_front();
                     check(rsp_hit == e.hit, e.req, $sformatf("hit flag @%h", e.addr),
                           int'(rsp_hit), int'(e.hit));
                     check(rsp_data == e.data, e.req, $sformatf("data @%h", e.addr),
                           int'(rsp_data), int'(e.data));
                  end
               end
            end
         end
         begin : watchdog
            repeat (100000) @(posedge clk);
            check(1'b0, "ALL", "watchdog expired", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
         end
      join_none

      repeat (3) @(negedge clk);
      // R5: reset state
      check(rsp_valid == 1'b0, "R5", "rsp_valid in reset", int'(rsp_valid), 0);
      check(flash_req == 1'b0, "R5", "flash_req in reset", int'(flash_req), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(rsp_valid == 1'b0, "R5", "rsp_valid after reset", int'(rsp_valid), 0);

      // R8: sweep fills slots 0..31, then turns back at 30
      for (int k = 0; k < 32; k++)
         fetch(15'(k * 4 + (k % 4)), 1'b0, k == 0 ? "R5" : "R8");
      for (int k = 0; k < 32; k++)
         fetch(15'(k * 4 + 3), 1'b1, "R8");
      fetch(15'd128, 1'b0, "R8");
      fetch(15'(31 * 4), 1'b1, "R8");
      fetch(15'd2, 1'b1, "R8");
      fetch(15'(30 * 4 + 1), 1'b0, "R8");

      // R1: byte select on a resident line
      for (int b = 0; b < 4; b++) fetch(15'(31 * 4 + b), 1'b1, "R1");

      // R11: bit 14 is part of the tag
      fetch(15'h4000, 1'b0, "R11");
      fetch(15'h0001, 1'b1, "R11");
      fetch(15'h4002, 1'b1, "R11");

      // R4: threshold 2
      cfg_thresh = 2'd2;
      lat_cfg = 2; fetch(15'h0100, 1'b0, "R4");
                   fetch(15'h0100, 1'b0, "R4");
      lat_cfg = 1; fetch(15'h0101, 1'b0, "R4");
                   fetch(15'h0101, 1'b0, "R4");
      lat_cfg = 3; fetch(15'h0102, 1'b0, "R4");
                   fetch(15'h0103, 1'b1, "R4");
      lat_cfg = 4; fetch(15'h0108, 1'b0, "R4");
                   fetch(15'h0109, 1'b1, "R4");
      cfg_thresh = 2'd0;
      lat_cfg = 1; fetch(15'h010C, 1'b0, "R4");
                   fetch(15'h010C, 1'b1, "R4");

      // R3: saturating stall count at threshold 3
      cfg_thresh = 2'd3;
      lat_cfg = 9; fetch(15'h0200, 1'b0, "R3");
                   fetch(15'h0200, 1'b1, "R3");
      lat_cfg = 3; fetch(15'h0204, 1'b0, "R3");
                   fetch(15'h0204, 1'b0, "R3");
      cfg_thresh = 2'd0;

      // R10: stray fetch during an outstanding miss
      lat_cfg = 4; fetch(15'h0300, 1'b0, "R10", 2, 15'h0310);
      lat_cfg = 1; fetch(15'h0310, 1'b0, "R10");
                   fetch(15'h0300, 1'b1, "R10");

      // R6: flush empties the store
      pulse_flush();
      fetch(15'h0300, 1'b0, "R6");
      fetch(15'h0200, 1'b0, "R6");
      fetch(15'h0301, 1'b1, "R6");

      // R7: flush in the return cycle drops the fill
      flush_on_fill = 1'b1;
      lat_cfg = 2; fetch(15'h0400, 1'b0, "R7");
      flush_on_fill = 1'b0;
      lat_cfg = 1; fetch(15'h0400, 1'b0, "R7");
                   fetch(15'h0300, 1'b0, "R7");

      // R9: pseudo-random placement still stores lines
      cfg_random = 1'b1;
      fetch(15'h0500, 1'b0, "R9");
      fetch(15'h0501, 1'b1, "R9");
      fetch(15'h0504, 1'b0, "R9");
      fetch(15'h0507, 1'b1, "R9");
      fetch(15'h0508, 1'b0, "R9");
      fetch(15'h050A, 1'b1, "R9");
      cfg_random = 1'b0;

      repeat (4) @(negedge clk);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule